// File: doc/BRIEF.md
# Stored Morse Message Sequencer

This block plays a small set of fixed messages as Morse code. It does not time the elements itself. It asks an external element timer for one element at a time: a dit, a dah or a letter space. Each request is held until the timer answers with a done strobe. The messages are kept as text, one byte per character. A combinational lookup turns each character into an element count and an element pattern. A space in the text marks a word boundary.

A message is chosen in two steps. First a memory button is pressed, which arms the selector. Then a paddle picks the message. Pressing the other memory button instead toggles either the paddle-swap mode or the sidetone-mute mode. Both modes are plain outputs for the neighbouring keyer logic.

At every word boundary the sequencer sets a cancel latch and samples the command input. If the command input is held, playback stops there. The latch keeps the same command press from also being taken as a speed-adjust request. It clears only once the command input has been released while the block is idle.

Top module: `morse_playback`

## Requirements
- R1: After reset, `elem_req`, `play_busy`, `play_done`, `swap_mode`, `mute_mode` and `mem_inhibit` are 0, and no element is requested while no button is used.
- R2: Memory button A followed by the dah paddle plays "CQ CQ CQ DE X1ABC X1ABC X1ABC + K". Button A followed by the dit paddle plays "CQ CQ CQ DE X1ABC X1ABC K". When both paddles are pressed, dah wins.
- R3: Memory button B followed by the dah paddle plays "CQ TEST CQ TEST DE X1ABC X1ABC K". Button B followed by the dit paddle plays "QRZ? DE X1ABC K".
- R4: Button A followed by button B toggles `swap_mode`. Button B followed by button A toggles `mute_mode`. Neither sequence requests any element.
- R5: `elem_kind` is 2'b00 for a dit, 2'b01 for a dah and 2'b10 for a letter space. A message starts with one letter space. Each character sends its elements in written order and then one letter space. Each space in the text adds one more letter space. The prosign `+` (dit dah dit dah dit) is sent as a single character.
- R6: `elem_req` stays high with a stable `elem_kind` until `elem_done` is sampled high. Each `elem_done` consumes exactly one element.
- R7: When a word-boundary letter space completes while `cmd_in` is high, playback stops and no further element is requested.
- R8: `play_done` is a single-cycle pulse, given once at the end of each playback, whether it completed or was cancelled.
- R9: `speed_adj_en` is high only when the block is idle, `cmd_in` is high and the cancel latch is clear. The latch is set at every word boundary and is cleared when the block is idle and `cmd_in` is low.
- R10: `mem_inhibit` is high for the whole playback, so the element timer uses plain timing without paddle memory.
- R11: Paddles and buttons are ignored while playback runs. After a playback or a toggle, all four inputs must be released before a new selection is accepted. A paddle alone while idle does nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_a_btn | input | 1 | Memory button A, active high |
| mem_b_btn | input | 1 | Memory button B, active high |
| dit_pad | input | 1 | Dit paddle, active high |
| dah_pad | input | 1 | Dah paddle, active high |
| cmd_in | input | 1 | Command/cancel input, active high |
| elem_done | input | 1 | Element timer finished the requested element |
| elem_req | output | 1 | An element is requested |
| elem_kind | output | 2 | Requested element: 00 dit, 01 dah, 10 letter space |
| play_busy | output | 1 | A message is playing |
| play_done | output | 1 | One-cycle pulse when playback ends |
| mem_inhibit | output | 1 | Tells the timer to run without paddle memory |
| swap_mode | output | 1 | Paddle-swap mode state |
| mute_mode | output | 1 | Sidetone-mute mode state |
| speed_adj_en | output | 1 | Command press may enter speed adjust |

## Verification
The assertions take two things for granted about the element timer. It raises `elem_done` only while a request is pending, and it gives one strobe per element. They also assume a new message is started only while the player is idle. The bench acts as that timer: it answers a request one cycle after seeing it and drops the strobe on the following cycle. Buttons and paddles change only at the falling clock edge and stay held through the playback they select.

// File: rtl/morse_play_pkg.sv
package morse_play_pkg;

    typedef enum logic [1:0] {
        KIND_DIT   = 2'd0,
        KIND_DAH   = 2'd1,
        KIND_SPACE = 2'd2
    } elem_kind_e;

    typedef enum logic [1:0] {
        MSG_CQ_LONG  = 2'd0,
        MSG_CQ_SHORT = 2'd1,
        MSG_CQ_TEST  = 2'd2,
        MSG_QRZ      = 2'd3
    } msg_id_e;

    // character code: element count plus pattern, first element at bit len-1, 1 = dah
    localparam int LEN_W = 3;
    localparam int PAT_W = 6;

    typedef struct packed {
        logic [LEN_W-1:0] len;
        logic [PAT_W-1:0] pat;
    } char_code_t;

    // stored message text; a space is a word boundary, '+' is the end-of-message prosign
    localparam TXT_LONG  = "CQ CQ CQ DE X1ABC X1ABC X1ABC + K";
    localparam TXT_SHORT = "CQ CQ CQ DE X1ABC X1ABC K";
    localparam TXT_TEST  = "CQ TEST CQ TEST DE X1ABC X1ABC K";
    localparam TXT_QRZ   = "QRZ? DE X1ABC K";

    localparam int LEN_LONG  = $bits(TXT_LONG) / 8;
    localparam int LEN_SHORT = $bits(TXT_SHORT) / 8;
    localparam int LEN_TEST  = $bits(TXT_TEST) / 8;
    localparam int LEN_QRZ   = $bits(TXT_QRZ) / 8;

    localparam int MAX_AB  = (LEN_LONG > LEN_SHORT) ? LEN_LONG : LEN_SHORT;
    localparam int MAX_CD  = (LEN_TEST > LEN_QRZ) ? LEN_TEST : LEN_QRZ;
    localparam int MSG_MAX = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int IDX_W   = $clog2(MSG_MAX + 1);

    function automatic char_code_t mk(input int n, input logic [PAT_W-1:0] p);
        char_code_t r;
        r.len = LEN_W'(n);
        r.pat = p;
        return r;
    endfunction

    function automatic logic [IDX_W-1:0] msg_len(input msg_id_e id);
        case (id)
            MSG_CQ_LONG:  return IDX_W'(LEN_LONG);
            MSG_CQ_SHORT: return IDX_W'(LEN_SHORT);
            MSG_CQ_TEST:  return IDX_W'(LEN_TEST);
            default:      return IDX_W'(LEN_QRZ);
        endcase
    endfunction

    function automatic logic [7:0] msg_char(input msg_id_e id, input logic [IDX_W-1:0] idx);
        int i;
        logic [7:0] c;
        i = int'(idx);
        c = 8'h00;
        case (id)
            MSG_CQ_LONG:  if (i < LEN_LONG)  c = TXT_LONG[8*(LEN_LONG-1-i) +: 8];
            MSG_CQ_SHORT: if (i < LEN_SHORT) c = TXT_SHORT[8*(LEN_SHORT-1-i) +: 8];
            MSG_CQ_TEST:  if (i < LEN_TEST)  c = TXT_TEST[8*(LEN_TEST-1-i) +: 8];
            default:      if (i < LEN_QRZ)   c = TXT_QRZ[8*(LEN_QRZ-1-i) +: 8];
        endcase
        return c;
    endfunction

    // text byte to Morse elements; unknown bytes return length 0
    function automatic char_code_t char_code(input logic [7:0] c);
        int d;
        logic [4:0] dp;
        if (c >= "0" && c <= "9") begin
            d  = int'(c) - int'("0");
            dp = (d <= 5) ? (5'h1F >> d) : ~(5'h1F >> (d - 5));
            return mk(5, {1'b0, dp});
        end
        case (c)
            "A": return mk(2, 6'b01);
            "B": return mk(4, 6'b1000);
            "C": return mk(4, 6'b1010);
            "D": return mk(3, 6'b100);
            "E": return mk(1, 6'b0);
            "F": return mk(4, 6'b0010);
            "G": return mk(3, 6'b110);
            "H": return mk(4, 6'b0000);
            "I": return mk(2, 6'b00);
            "J": return mk(4, 6'b0111);
            "K": return mk(3, 6'b101);
            "L": return mk(4, 6'b0100);
            "M": return mk(2, 6'b11);
            "N": return mk(2, 6'b10);
            "O": return mk(3, 6'b111);
            "P": return mk(4, 6'b0110);
            "Q": return mk(4, 6'b1101);
            "R": return mk(3, 6'b010);
            "S": return mk(3, 6'b000);
            "T": return mk(1, 6'b1);
            "U": return mk(3, 6'b001);
            "V": return mk(4, 6'b0001);
            "W": return mk(3, 6'b011);
            "X": return mk(4, 6'b1001);
            "Y": return mk(4, 6'b1011);
            "Z": return mk(4, 6'b1100);
            "?": return mk(6, 6'b001100);
            "+": return mk(5, 6'b01010);
            "=": return mk(5, 6'b10001);
            "/": return mk(5, 6'b10010);
            default: return mk(0, 6'b0);
        endcase
    endfunction

endpackage

// File: rtl/morse_msg_select.sv
module morse_msg_select
    import morse_play_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    mem_a,
    input  logic    mem_b,
    input  logic    dit,
    input  logic    dah,
    input  logic    play_busy,
    input  logic    play_done,
    output logic    start,
    output msg_id_e start_id,
    output logic    swap_mode,
    output logic    mute_mode,
    output logic    sel_idle
);

    typedef enum logic [2:0] {
        SEL_IDLE,
        SEL_ARM_A,
        SEL_ARM_B,
        SEL_PLAY,
        SEL_RELEASE
    } sel_state_e;

    sel_state_e st;
    logic       any_in;

    assign any_in   = mem_a | mem_b | dit | dah;
    assign sel_idle = (st == SEL_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= SEL_IDLE;
            start     <= 1'b0;
            start_id  <= MSG_CQ_LONG;
            swap_mode <= 1'b0;
            mute_mode <= 1'b0;
        end else begin
            start <= 1'b0;
            case (st)
                SEL_IDLE: begin
                    if (mem_a)      st <= SEL_ARM_A;
                    else if (mem_b) st <= SEL_ARM_B;
                end
                SEL_ARM_A: begin
                    if (dah) begin
                        start    <= 1'b1;
                        start_id <= MSG_CQ_LONG;
                        st       <= SEL_PLAY;
                    end else if (dit) begin
                        start    <= 1'b1;
                        start_id <= MSG_CQ_SHORT;
                        st       <= SEL_PLAY;
                    end else if (mem_b) begin
                        swap_mode <= ~swap_mode;
                        st        <= SEL_RELEASE;
                    end
                end
                SEL_ARM_B: begin
                    if (dah) begin
                        start    <= 1'b1;
                        start_id <= MSG_CQ_TEST;
                        st       <= SEL_PLAY;
                    end else if (dit) begin
                        start    <= 1'b1;
                        start_id <= MSG_QRZ;
                        st       <= SEL_PLAY;
                    end else if (mem_a) begin
                        mute_mode <= ~mute_mode;
                        st        <= SEL_RELEASE;
                    end
                end
                SEL_PLAY: begin
                    if (play_done) st <= SEL_RELEASE;
                end
                SEL_RELEASE: begin
                    if (!any_in) st <= SEL_IDLE;
                end
                default: st <= SEL_IDLE;
            endcase
        end
    end

    // R4: mode bits only change while no message is playing
    a_r4_toggle_when_quiet: assert property (@(posedge clk) disable iff (rst)
        (swap_mode != $past(swap_mode) || mute_mode != $past(mute_mode)) |-> !$past(play_busy));

    // R11: a new message is only launched into an idle player
    a_r11_start_into_idle: assert property (@(posedge clk) disable iff (rst)
        start |-> !play_busy);

endmodule

// File: rtl/morse_msg_seq.sv
module morse_msg_seq
    import morse_play_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  msg_id_e    start_id,
    input  logic       cmd_in,
    input  logic       elem_done,
    output logic       elem_req,
    output elem_kind_e elem_kind,
    output logic       busy,
    output logic       done,
    output logic       cancel_latch
);

    typedef enum logic [2:0] {
        P_IDLE,
        P_LEAD,
        P_LOAD,
        P_ELEM,
        P_GAP,
        P_WGAP
    } play_state_e;

    play_state_e      state;
    msg_id_e          id;
    logic [IDX_W-1:0] idx;
    logic [LEN_W-1:0] eidx;
    char_code_t       code;
    logic [7:0]       cur_ch;
    char_code_t       cur_code;
    logic [PAT_W-1:0] shifted;

    assign cur_ch   = msg_char(id, idx);
    assign cur_code = char_code(cur_ch);
    assign busy     = (state != P_IDLE);
    assign elem_req = (state == P_LEAD) || (state == P_ELEM) ||
                      (state == P_GAP)  || (state == P_WGAP);

    always_comb begin
        shifted   = code.pat >> (code.len - LEN_W'(1) - eidx);
        elem_kind = KIND_SPACE;
        if (state == P_ELEM) elem_kind = shifted[0] ? KIND_DAH : KIND_DIT;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= P_IDLE;
            id           <= MSG_CQ_LONG;
            idx          <= '0;
            eidx         <= '0;
            code         <= '0;
            done         <= 1'b0;
            cancel_latch <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                P_IDLE: begin
                    if (!cmd_in) cancel_latch <= 1'b0;
                    if (start) begin
                        id    <= start_id;
                        idx   <= '0;
                        state <= P_LEAD;
                    end
                end
                P_LEAD: begin
                    if (elem_done) state <= P_LOAD;
                end
                P_LOAD: begin
                    if (idx == msg_len(id)) begin
                        state <= P_IDLE;
                        done  <= 1'b1;
                    end else if (cur_ch == " ") begin
                        state <= P_WGAP;
                    end else if (cur_code.len == '0) begin
                        idx <= idx + 1'b1;
                    end else begin
                        code  <= cur_code;
                        eidx  <= '0;
                        state <= P_ELEM;
                    end
                end
                P_ELEM: begin
                    if (elem_done) begin
                        if (eidx == code.len - LEN_W'(1)) state <= P_GAP;
                        else                              eidx  <= eidx + 1'b1;
                    end
                end
                P_GAP: begin
                    if (elem_done) begin
                        idx   <= idx + 1'b1;
                        state <= P_LOAD;
                    end
                end
                P_WGAP: begin
                    if (elem_done) begin
                        cancel_latch <= 1'b1;
                        idx          <= idx + 1'b1;
                        if (cmd_in) begin
                            state <= P_IDLE;
                            done  <= 1'b1;
                        end else begin
                            state <= P_LOAD;
                        end
                    end
                end
                default: state <= P_IDLE;
            endcase
        end
    end

    // R6: a pending request holds its kind until the timer answers
    a_r6_req_hold: assert property (@(posedge clk) disable iff (rst)
        (elem_req && !elem_done) |=> (elem_req && $stable(elem_kind)));

    // R8: the end-of-playback pulse lasts one cycle
    a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7: once playback has ended nothing more is requested
    a_r7_quiet_after_end: assert property (@(posedge clk) disable iff (rst)
        done |-> (!elem_req && !start));

endmodule

// File: rtl/morse_playback.sv
module morse_playback
    import morse_play_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       mem_a_btn,
    input  logic       mem_b_btn,
    input  logic       dit_pad,
    input  logic       dah_pad,
    input  logic       cmd_in,
    input  logic       elem_done,
    output logic       elem_req,
    output logic [1:0] elem_kind,
    output logic       play_busy,
    output logic       play_done,
    output logic       mem_inhibit,
    output logic       swap_mode,
    output logic       mute_mode,
    output logic       speed_adj_en
);

    logic       start;
    msg_id_e    start_id;
    logic       sel_idle;
    logic       cancel_latch;
    elem_kind_e kind;

    morse_msg_select u_select (
        .clk       (clk),
        .rst       (rst),
        .mem_a     (mem_a_btn),
        .mem_b     (mem_b_btn),
        .dit       (dit_pad),
        .dah       (dah_pad),
        .play_busy (play_busy),
        .play_done (play_done),
        .start     (start),
        .start_id  (start_id),
        .swap_mode (swap_mode),
        .mute_mode (mute_mode),
        .sel_idle  (sel_idle)
    );

    morse_msg_seq u_seq (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .start_id     (start_id),
        .cmd_in       (cmd_in),
        .elem_done    (elem_done),
        .elem_req     (elem_req),
        .elem_kind    (kind),
        .busy         (play_busy),
        .done         (play_done),
        .cancel_latch (cancel_latch)
    );

    assign elem_kind    = kind;
    assign mem_inhibit  = play_busy;
    assign speed_adj_en = sel_idle & ~play_busy & cmd_in & ~cancel_latch;

    // R10: every element of a playback is timed without paddle memory
    a_r10_plain_timing: assert property (@(posedge clk) disable iff (rst)
        elem_req |-> mem_inhibit);

    // R9: a latched cancel keeps the command press out of speed adjust
    a_r9_latch_blocks_speed: assert property (@(posedge clk) disable iff (rst)
        cancel_latch |-> !speed_adj_en);

    // R9: speed adjust is never offered during playback
    a_r9_no_speed_while_busy: assert property (@(posedge clk) disable iff (rst)
        play_busy |-> !speed_adj_en);

endmodule

// File: tb/morse_playback_bench.sv
`timescale 1ns/1ps
module morse_playback_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mem_a_btn = 1'b0, mem_b_btn = 1'b0, dit_pad = 1'b0, dah_pad = 1'b0;
    logic       cmd_in = 1'b0, elem_done = 1'b0;
    logic       elem_req, play_busy, play_done, mem_inhibit;
    logic       swap_mode, mute_mode, speed_adj_en;
    logic [1:0] elem_kind;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    localparam int WATCHDOG = 150000;

    always #10 clk = ~clk;

    morse_playback u_morse_playback (
        .clk(clk), .rst(rst), .mem_a_btn(mem_a_btn), .mem_b_btn(mem_b_btn),
        .dit_pad(dit_pad), .dah_pad(dah_pad), .cmd_in(cmd_in), .elem_done(elem_done),
        .elem_req(elem_req), .elem_kind(elem_kind), .play_busy(play_busy),
        .play_done(play_done), .mem_inhibit(mem_inhibit), .swap_mode(swap_mode),
        .mute_mode(mute_mode), .speed_adj_en(speed_adj_en)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc == WATCHDOG) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run hung, actual=%0d cycles expected<%0d", cyc, WATCHDOG);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string act, input string exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%s expected=%s", req, act, exp);
        end
    endtask

    // vectors: {button (0=A,1=B), paddles {dah,dit}, message number}
    localparam logic [4:0] VEC [5] = '{
        {1'b0, 2'b10, 2'd0},
        {1'b0, 2'b01, 2'd1},
        {1'b1, 2'b10, 2'd2},
        {1'b1, 2'b01, 2'd3},
        {1'b0, 2'b11, 2'd0}
    };

    function automatic string msg_text(input int m);
        case (m)
            0: return "CQ CQ CQ DE X1ABC X1ABC X1ABC + K";
            1: return "CQ CQ CQ DE X1ABC X1ABC K";
            2: return "CQ TEST CQ TEST DE X1ABC X1ABC K";
            default: return "QRZ? DE X1ABC K";
        endcase
    endfunction

    function automatic string morse(input byte c);
        case (c)
            "A": return ".-";
            "B": return "-...";
            "C": return "-.-.";
            "D": return "-..";
            "E": return ".";
            "K": return "-.-";
            "Q": return "--.-";
            "R": return ".-.";
            "S": return "...";
            "T": return "-";
            "X": return "-..-";
            "Z": return "--..";
            "1": return ".----";
            "?": return "..--..";
            "+": return ".-.-.";
            default: return "#";
        endcase
    endfunction

    // R5: lead space, elements then a space per character, one more space per word gap
    function automatic string expect_seq(input string t);
        string s;
        s = "s";
        for (int i = 0; i < t.len(); i++) begin
            if (t[i] == " ") s = {s, "s"};
            else             s = {s, morse(t[i]), "s"};
        end
        return s;
    endfunction

    // acts as the element timer until playback ends
    task automatic serve(output string got, output int dones, output int inh_bad);
        int guard;
        got = "";
        dones = 0;
        inh_bad = 0;
        guard = 0;
        while (dones == 0 && guard < 20000) begin
            @(negedge clk);
            guard++;
            if (play_done) dones++;
            if (elem_done) begin
                elem_done = 1'b0;
            end else if (elem_req) begin
                if (!mem_inhibit) inh_bad++;
                case (elem_kind)
                    2'b00: got = {got, "."};
                    2'b01: got = {got, "-"};
                    2'b10: got = {got, "s"};
                    default: got = {got, "?"};
                endcase
                elem_done = 1'b1;
            end
        end
        elem_done = 1'b0;
    endtask

    task automatic release_all();
        @(negedge clk);
        mem_a_btn = 0; mem_b_btn = 0; dit_pad = 0; dah_pad = 0;
        repeat (3) @(negedge clk);
    endtask

    task automatic play(input bit btn, input logic [1:0] pads, input string exp, input string tag);
        string got;
        int dn, inh, extra_done, extra_req;
        @(negedge clk);
        if (btn) mem_b_btn = 1; else mem_a_btn = 1;
        repeat (2) @(negedge clk);
        dah_pad = pads[1];
        dit_pad = pads[0];
        serve(got, dn, inh);
        chk(got == exp, tag, got, exp);
        chk(inh == 0, "R10 inhibit during playback", $sformatf("%0d", inh), "0");
        // R11: inputs still held after the end must not restart playback
        extra_done = 0;
        extra_req = 0;
        repeat (8) begin
            @(negedge clk);
            if (play_done) extra_done++;
            if (elem_req || play_busy) extra_req++;
        end
        chk(dn == 1 && extra_done == 0, "R8 single done pulse",
            $sformatf("%0d", dn + extra_done), "1");
        chk(extra_req == 0, "R11 held inputs ignored after end",
            $sformatf("%0d", extra_req), "0");
        release_all();
    endtask

    initial begin
        string got;
        int dn, inh, bad;
        logic [4:0] v;

        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk(!elem_req && !play_busy && !play_done && !swap_mode && !mute_mode && !mem_inhibit,
            "R1 reset outputs",
            $sformatf("%b%b%b%b%b%b", elem_req, play_busy, play_done, swap_mode, mute_mode, mem_inhibit),
            "000000");

        // vector table: R2 and R3 messages, R5 encoding, R6 handshake
        for (int k = 0; k < 5; k++) begin
            v = VEC[k];
            play(v[4], v[3:2], expect_seq(msg_text(int'(v[1:0]))),
                 v[4] ? "R3 message content" : (v[3:2] == 2'b11 ? "R2 dah priority" : "R2 message content"));
        end

        // R11: paddle alone in idle does nothing
        @(negedge clk);
        dit_pad = 1;
        dah_pad = 1;
        bad = 0;
        repeat (10) begin
            @(negedge clk);
            if (elem_req || play_busy) bad++;
        end
        chk(bad == 0, "R11 paddle alone idle", $sformatf("%0d", bad), "0");
        release_all();

        // R4 swap toggle: A then B
        for (int t = 0; t < 2; t++) begin
            @(negedge clk); mem_a_btn = 1;
            repeat (2) @(negedge clk); mem_b_btn = 1;
            bad = 0;
            repeat (4) begin @(negedge clk); if (elem_req || play_busy) bad++; end
            chk(swap_mode == (t == 0) && bad == 0, "R4 swap toggle",
                $sformatf("swap=%b req=%0d", swap_mode, bad),
                $sformatf("swap=%b req=0", t == 0));
            release_all();
        end
        // R4 mute toggle: B then A, swap unchanged
        @(negedge clk); mem_b_btn = 1;
        repeat (2) @(negedge clk); mem_a_btn = 1;
        repeat (4) @(negedge clk);
        chk(mute_mode && !swap_mode && !play_busy, "R4 mute toggle",
            $sformatf("mute=%b swap=%b", mute_mode, swap_mode), "mute=1 swap=0");
        release_all();

        // R9: with the latch clear a command press enables speed adjust
        @(negedge clk); cmd_in = 1;
        @(negedge clk);
        chk(speed_adj_en, "R9 speed adjust idle", $sformatf("%b", speed_adj_en), "1");
        cmd_in = 0;
        @(negedge clk);

        // R7 cancel at the first word boundary
        cmd_in = 1;
        @(negedge clk); mem_a_btn = 1;
        repeat (2) @(negedge clk); dah_pad = 1;
        serve(got, dn, inh);
        chk(got == "s-.-.s--.-ss", "R7 cancel at word gap", got, "s-.-.s--.-ss");
        chk(dn == 1, "R8 done on cancel", $sformatf("%0d", dn), "1");
        release_all();
        bad = 0;
        repeat (5) begin @(negedge clk); if (elem_req || play_busy) bad++; end
        chk(bad == 0, "R7 no requests after cancel", $sformatf("%0d", bad), "0");
        // R9: latch still set while cmd stays held
        chk(!speed_adj_en, "R9 latch blocks speed adjust", $sformatf("%b", speed_adj_en), "0");
        cmd_in = 0;
        repeat (2) @(negedge clk);
        cmd_in = 1;
        @(negedge clk);
        chk(speed_adj_en, "R9 latch cleared on release", $sformatf("%b", speed_adj_en), "1");
        cmd_in = 0;
        @(negedge clk);

        // R1: reset returns modes to zero
        rst = 1;
        @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(!mute_mode && !swap_mode && !elem_req, "R1 reset clears modes",
            $sformatf("mute=%b swap=%b", mute_mode, swap_mode), "mute=0 swap=0");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule